// File: doc/BRIEF.md
# Retirement Trace Consistency Checker

This block is a passive monitor placed beside a 32-bit RISC-V core. It watches the per-instruction retirement record the core emits. Each cycle with the record's valid bit high, it tests the record against a set of structural rules. When valid is low, every other field carries no meaning and is ignored.

It does not decode instructions or recompute results. It checks these rules:
- the retirement index advances with no gaps and no repeats;
- the trap-entry flag matches a discontinuity in the program counter;
- the privilege and XLEN encodings are legal;
- register slot zero reads and writes as zero;
- an all-zero instruction word traps.

Each rule has its own sticky error bit, and the retirement index of the first failing record is kept. The monitor never applies back-pressure: there is no ready signal, and the core may present a record every cycle. Results appear one clock after the record is sampled.

Top module: `trc_checker`

## Requirements
- R1: While reset is asserted, and on the first sampling edge after it, `err_flags`, `err_any` and `first_fail_order` are all zero.
- R2: The first valid record after reset must carry order 0. Each later valid record must carry the previous record's order plus one. Otherwise bit 0 of `err_flags` is set.
- R3: The trap-entry flag must be high exactly when `pc_before` differs from `pc_after` of the previous valid record. Otherwise bit 1 is set. The first valid record after reset is exempt.
- R4: A privilege field of 2 (encoding: 0 user, 1 supervisor, 2 reserved, 3 machine) sets bit 2.
- R5: An XLEN field other than 1 (1 means 32-bit, 2 means 64-bit) sets bit 3.
- R6: A source-1 index of zero with nonzero source-1 data sets bit 4. A source-2 index of zero with nonzero source-2 data sets bit 5.
- R7: A destination index of zero with nonzero write data sets bit 6.
- R8: An instruction word of 0x00000000 with the trap bit low sets bit 7.
- R9: When `in_valid` is low, no flag changes and the ordering and PC history are left untouched.
- R10: Error bits stay set until reset. `err_any` is high whenever any bit of `err_flags` is set.
- R11: `first_fail_order` takes the order field of the first record that breaks any rule. It keeps that value through later failures.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Record present this cycle |
| in_order | input | 64 | Retirement index |
| in_insn | input | 32 | Instruction word |
| in_trap | input | 1 | Instruction trapped |
| in_intr | input | 1 | First instruction of a trap handler |
| in_mode | input | 2 | Privilege level |
| in_ixl | input | 2 | Current XLEN encoding |
| in_src1_idx | input | 5 | Source-1 register index |
| in_src1_val | input | 32 | Source-1 data before execution |
| in_src2_idx | input | 5 | Source-2 register index |
| in_src2_val | input | 32 | Source-2 data before execution |
| in_dst_idx | input | 5 | Destination register index |
| in_dst_val | input | 32 | Destination write data |
| in_pc_before | input | 32 | PC of the retired instruction |
| in_pc_after | input | 32 | PC of the next instruction |
| err_flags | output | 8 | Sticky per-rule error bits |
| err_any | output | 1 | OR of all error bits |
| first_fail_order | output | 64 | Order of the first failing record |

## Verification
The assertions assume two things about the inputs. Reset is asserted from time zero. Records are sampled only on rising edges, with their fields stable across the edge. The bench meets both conditions: it holds reset low from the start and changes every input only on the falling edge. Within that envelope it may present any record at all, illegal ones included. The illegal records are what drive the flag checks. Bad records are inserted one at a time after a fresh reset, so that each flag bit can be tied to one rule.

// File: rtl/trc_pkg.sv
package trc_pkg;
  localparam int NUM_RULES = 8;

  localparam int RB_ORDER = 0;
  localparam int RB_INTR  = 1;
  localparam int RB_MODE  = 2;
  localparam int RB_IXL   = 3;
  localparam int RB_SRC1Z = 4;
  localparam int RB_SRC2Z = 5;
  localparam int RB_DSTZ  = 6;
  localparam int RB_TRAP  = 7;

  typedef enum logic [1:0] {
    PRIV_U    = 2'd0,
    PRIV_S    = 2'd1,
    PRIV_RSVD = 2'd2,
    PRIV_M    = 2'd3
  } priv_e;

  localparam logic [1:0] IXL_32 = 2'd1;
  localparam logic [1:0] IXL_64 = 2'd2;
endpackage

// File: rtl/trc_seq_track.sv
module trc_seq_track #(
  parameter int ORDER_W = 64,
  parameter int XLEN    = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [ORDER_W-1:0] in_order,
  input  logic [XLEN-1:0]    in_pc_before,
  input  logic [XLEN-1:0]    in_pc_after,
  input  logic               in_intr,
  output logic               order_bad,
  output logic               intr_bad
);
  logic [ORDER_W-1:0] exp_order;
  logic [XLEN-1:0]    prev_pc_after;
  logic               have_prev;
  logic               pc_jump;

  assign pc_jump   = (in_pc_before != prev_pc_after);
  assign order_bad = (in_order != exp_order);
  assign intr_bad  = have_prev && (in_intr != pc_jump);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_order     <= '0;
      prev_pc_after <= '0;
      have_prev     <= 1'b0;
    end else if (in_valid) begin
      exp_order     <= in_order + ORDER_W'(1);
      prev_pc_after <= in_pc_after;
      have_prev     <= 1'b1;
    end
  end

  // R3
  history_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> have_prev);

  // R9
  idle_hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(exp_order) && $stable(prev_pc_after) && $stable(have_prev)));
endmodule

// File: rtl/trc_field_rules.sv
module trc_field_rules
  import trc_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int AW   = 5,
  parameter int NSRC = 2
) (
  input  logic [1:0]          in_mode,
  input  logic [1:0]          in_ixl,
  input  logic [XLEN-1:0]     in_insn,
  input  logic                in_trap,
  input  logic [NSRC-1:0][AW-1:0]   src_idx,
  input  logic [NSRC-1:0][XLEN-1:0] src_val,
  input  logic [AW-1:0]       dst_idx,
  input  logic [XLEN-1:0]     dst_val,
  output logic                mode_bad,
  output logic                ixl_bad,
  output logic [NSRC-1:0]     src_bad,
  output logic                dst_bad,
  output logic                trap_bad
);
  localparam logic [1:0] LEGAL_IXL = (XLEN == 64) ? IXL_64 : IXL_32;

  assign mode_bad = (priv_e'(in_mode) == PRIV_RSVD);
  assign ixl_bad  = (in_ixl != LEGAL_IXL);
  assign dst_bad  = (dst_idx == '0) && (dst_val != '0);
  assign trap_bad = (in_insn == '0) && !in_trap;

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    assign src_bad[s] = (src_idx[s] == '0) && (src_val[s] != '0);
  end
endmodule

// File: rtl/trc_err_log.sv
module trc_err_log #(
  parameter int NUM     = 8,
  parameter int ORDER_W = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [NUM-1:0]     viol,
  input  logic [ORDER_W-1:0] in_order,
  output logic [NUM-1:0]     err_flags,
  output logic               err_any,
  output logic [ORDER_W-1:0] first_fail_order
);
  logic hit;
  assign hit     = in_valid && (viol != '0);
  assign err_any = (err_flags != '0);

  for (genvar b = 0; b < NUM; b++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    err_flags[b] <= 1'b0;
      else if (in_valid && viol[b])  err_flags[b] <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              first_fail_order <= '0;
    else if (hit && !err_any) first_fail_order <= in_order;
  end

  // R10
  flags_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flags & $past(err_flags)) == $past(err_flags));

  // R11
  first_order_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_any |=> $stable(first_fail_order));
endmodule

// File: rtl/trc_checker.sv
module trc_checker
  import trc_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int ORDER_W = 64,
  parameter int AW      = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [ORDER_W-1:0] in_order,
  input  logic [XLEN-1:0]    in_insn,
  input  logic               in_trap,
  input  logic               in_intr,
  input  logic [1:0]         in_mode,
  input  logic [1:0]         in_ixl,
  input  logic [AW-1:0]      in_src1_idx,
  input  logic [XLEN-1:0]    in_src1_val,
  input  logic [AW-1:0]      in_src2_idx,
  input  logic [XLEN-1:0]    in_src2_val,
  input  logic [AW-1:0]      in_dst_idx,
  input  logic [XLEN-1:0]    in_dst_val,
  input  logic [XLEN-1:0]    in_pc_before,
  input  logic [XLEN-1:0]    in_pc_after,
  output logic [NUM_RULES-1:0] err_flags,
  output logic               err_any,
  output logic [ORDER_W-1:0] first_fail_order
);
  localparam int NSRC = 2;

  logic [NSRC-1:0][AW-1:0]   src_idx;
  logic [NSRC-1:0][XLEN-1:0] src_val;
  logic [NSRC-1:0]           src_bad;
  logic order_bad, intr_bad, mode_bad, ixl_bad, dst_bad, trap_bad;
  logic [NUM_RULES-1:0] viol;

  assign src_idx = {in_src2_idx, in_src1_idx};
  assign src_val = {in_src2_val, in_src1_val};

  trc_seq_track #(.ORDER_W(ORDER_W), .XLEN(XLEN)) u_seq (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_order(in_order),
    .in_pc_before(in_pc_before), .in_pc_after(in_pc_after), .in_intr(in_intr),
    .order_bad(order_bad), .intr_bad(intr_bad)
  );

  trc_field_rules #(.XLEN(XLEN), .AW(AW), .NSRC(NSRC)) u_fields (
    .in_mode(in_mode), .in_ixl(in_ixl), .in_insn(in_insn), .in_trap(in_trap),
    .src_idx(src_idx), .src_val(src_val), .dst_idx(in_dst_idx), .dst_val(in_dst_val),
    .mode_bad(mode_bad), .ixl_bad(ixl_bad), .src_bad(src_bad),
    .dst_bad(dst_bad), .trap_bad(trap_bad)
  );

  always_comb begin
    viol           = '0;
    viol[RB_ORDER] = order_bad;
    viol[RB_INTR]  = intr_bad;
    viol[RB_MODE]  = mode_bad;
    viol[RB_IXL]   = ixl_bad;
    viol[RB_SRC1Z] = src_bad[0];
    viol[RB_SRC2Z] = src_bad[1];
    viol[RB_DSTZ]  = dst_bad;
    viol[RB_TRAP]  = trap_bad;
  end

  trc_err_log #(.NUM(NUM_RULES), .ORDER_W(ORDER_W)) u_log (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .viol(viol), .in_order(in_order),
    .err_flags(err_flags), .err_any(err_any), .first_fail_order(first_fail_order)
  );

  // R4
  rsvd_mode_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_mode == 2'd2) |=> err_flags[RB_MODE]);

  // R8
  zero_insn_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_insn == '0 && !in_trap) |=> err_flags[RB_TRAP]);

  // R9
  idle_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(err_flags));

  // R10
  any_tracks_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_flags[RB_ORDER] |-> err_any);
endmodule

// File: tb/tb_trc_checker.sv
module tb_trc_checker;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        t_valid = 1'b0;
  logic [63:0] t_order = '0;
  logic [31:0] t_insn = '0;
  logic        t_trap = 1'b0, t_intr = 1'b0;
  logic [1:0]  t_mode = '0, t_ixl = '0;
  logic [4:0]  t_s1a = '0, t_s2a = '0, t_da = '0;
  logic [31:0] t_s1d = '0, t_s2d = '0, t_dd = '0, t_pcr = '0, t_pcw = '0;

  logic [7:0]  err_flags;
  logic        err_any;
  logic [63:0] first_fail_order;

  trc_checker dut (
    .clk(clk), .rst_n(rst_n), .in_valid(t_valid), .in_order(t_order),
    .in_insn(t_insn), .in_trap(t_trap), .in_intr(t_intr), .in_mode(t_mode),
    .in_ixl(t_ixl), .in_src1_idx(t_s1a), .in_src1_val(t_s1d),
    .in_src2_idx(t_s2a), .in_src2_val(t_s2d), .in_dst_idx(t_da),
    .in_dst_val(t_dd), .in_pc_before(t_pcr), .in_pc_after(t_pcw),
    .err_flags(err_flags), .err_any(err_any), .first_fail_order(first_fail_order)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  logic [7:0]  m_flags;
  logic        m_any;
  logic [63:0] m_first, m_exp;
  logic [31:0] m_pcw;
  logic        m_have;

  task automatic compare(input string tag);
    n_chk++;
    if (err_flags !== m_flags || err_any !== m_any || first_fail_order !== m_first) begin
      n_bad++;
      $display("FAIL %s: flags=%h any=%b first=%0d expected flags=%h any=%b first=%0d",
               tag, err_flags, err_any, first_fail_order, m_flags, m_any, m_first);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; t_valid = 1'b0;
    m_flags = '0; m_any = 1'b0; m_first = '0; m_exp = '0; m_pcw = '0; m_have = 1'b0;
    repeat (2) @(negedge clk);
    compare("R1 during reset");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1 after reset");
  endtask

  // a clean record continuing the current stream
  task automatic clean();
    t_order = m_exp;
    t_pcr   = m_have ? m_pcw : 32'h0000_0100;
    t_pcw   = t_pcr + 32'd4;
    t_intr  = 1'b0; t_trap = 1'b0;
    t_mode  = 2'd3; t_ixl = 2'd1;
    t_insn  = 32'h0000_0013;
    t_s1a = 5'd1; t_s1d = 32'h1234_5678;
    t_s2a = 5'd2; t_s2d = 32'h0BAD_F00D;
    t_da  = 5'd3; t_dd  = 32'h0000_0042;
  endtask

  task automatic send(input string tag);
    logic [7:0] v;
    v = '0;
    v[0] = (t_order != m_exp);
    v[1] = m_have && (t_intr != (t_pcr != m_pcw));
    v[2] = (t_mode == 2'd2);
    v[3] = (t_ixl != 2'd1);
    v[4] = (t_s1a == 5'd0) && (t_s1d != 32'd0);
    v[5] = (t_s2a == 5'd0) && (t_s2d != 32'd0);
    v[6] = (t_da == 5'd0) && (t_dd != 32'd0);
    v[7] = (t_insn == 32'd0) && !t_trap;
    if (!m_any && v != 8'd0) m_first = t_order;
    m_flags = m_flags | v;
    m_any   = (m_flags != 8'd0);
    m_exp   = t_order + 64'd1;
    m_pcw   = t_pcw;
    m_have  = 1'b1;
    t_valid = 1'b1;
    @(negedge clk);
    t_valid = 1'b0;
    compare(tag);
  endtask

  task automatic idle_garbage(input string tag);
    t_valid = 1'b0;
    t_order = 64'hDEAD; t_mode = 2'd2; t_ixl = 2'd0; t_insn = '0; t_trap = 1'b0;
    t_s1a = '0; t_s1d = 32'hFFFF_FFFF; t_da = '0; t_dd = 32'h1; t_intr = 1'b1;
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();

    // R2 R3: a clean chained stream with one properly flagged jump
    for (int i = 0; i < 24; i++) begin
      clean();
      if (i == 10) begin t_pcr = 32'h0000_8000; t_pcw = 32'h0000_8004; t_intr = 1'b1; end
      send("R2 R3 clean stream");
    end

    // R9: idle cycles with illegal content, then the stream resumes
    for (int i = 0; i < 4; i++) idle_garbage("R9 idle ignored");
    clean(); send("R9 history kept");

    // R2: first record not order 0
    do_reset();
    clean(); t_order = 64'd5; send("R2 first order");
    // R2: gap in a running stream, R11 first failing order
    do_reset();
    for (int i = 0; i < 3; i++) begin clean(); send("R2 run"); end
    clean(); t_order = m_exp + 64'd2; send("R2 gap");
    // R2: repeated index
    do_reset();
    for (int i = 0; i < 3; i++) begin clean(); send("R2 run"); end
    clean(); t_order = m_exp - 64'd1; send("R2 repeat");

    // R3: first record exempt, then jump without intr
    do_reset();
    clean(); t_intr = 1'b1; t_pcr = 32'h4000; t_pcw = 32'h4004; send("R3 first exempt");
    clean(); send("R3 continuous");
    clean(); t_pcr = 32'h9000; t_pcw = 32'h9004; send("R3 missing intr");
    // R3: intr without a jump
    do_reset();
    clean(); send("R3 run");
    clean(); t_intr = 1'b1; send("R3 spurious intr");

    // R4 R5: sweep privilege and XLEN codes
    for (int m = 0; m < 4; m++) begin
      do_reset();
      clean(); send("R4 lead");
      clean(); t_mode = 2'(m); send("R4 mode sweep");
    end
    for (int x = 0; x < 4; x++) begin
      do_reset();
      clean(); send("R5 lead");
      clean(); t_ixl = 2'(x); send("R5 ixl sweep");
    end

    // R6 R7: zero-index data rules, index x data sweep
    for (int a = 0; a < 3; a++) begin
      for (int d = 0; d < 3; d++) begin
        logic [4:0]  ia;
        logic [31:0] dv;
        ia = (a == 0) ? 5'd0 : (a == 1) ? 5'd1 : 5'd31;
        dv = (d == 0) ? 32'd0 : (d == 1) ? 32'd1 : 32'h8000_0000;
        do_reset();
        clean(); t_s1a = ia; t_s1d = dv; send("R6 src1");
        clean(); t_s2a = ia; t_s2d = dv; send("R6 src2");
        do_reset();
        clean(); t_da = ia; t_dd = dv; send("R7 dst");
      end
    end

    // R8: instruction word x trap
    for (int z = 0; z < 2; z++) begin
      for (int tr = 0; tr < 2; tr++) begin
        do_reset();
        clean(); t_insn = (z == 0) ? 32'd0 : 32'h0000_0073; t_trap = tr[0];
        send("R8 insn trap");
      end
    end

    // R10 R11: several failures, sticky through clean records
    do_reset();
    for (int i = 0; i < 3; i++) begin clean(); send("R11 lead"); end
    clean(); t_mode = 2'd2; send("R11 first fail");
    clean(); t_ixl = 2'd2; send("R11 second fail");
    clean(); t_insn = '0; send("R11 third fail");
    for (int i = 0; i < 6; i++) begin clean(); send("R10 sticky"); end
    idle_garbage("R10 sticky idle");

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule